// File: doc/BRIEF.md
# Masked Vector Floating-Point Mask Comparator

This block carries out one vector floating-point comparison over a whole register group and walks the elements one per cycle. A start pulse loads the decoded instruction fields, the element width, the active length and the group length. The block then reads element `i` of the second source vector. It compares that element with either element `i` of the first source vector or a scalar, and writes the one-bit outcome into a mask image at index `i`. Seven relations are supported: equal, not-equal, less-than, less-or-equal, greater-than, greater-or-equal and ordered. Operands are half, single or double precision values in binary interchange format.

Two kinds of element are never written in the body. Elements switched off by the v0 mask keep their old bit and raise no exception. Elements past the active length, up to the group length, are cleared. An invalid-operation flag collects over the run. Equal, not-equal and ordered only react to signaling NaNs. The four ordering relations react to any NaN. Illegal encodings are reported through a separate flag and produce no writes.

The sequencer has three states. IDLE waits for `start`. An illegal encoding or a zero group length goes IDLE->DONE, and a legal start goes IDLE->RUN. RUN reads one index per cycle, takes RUN->RUN while more indices remain and RUN->DONE after the last one. DONE raises `done` for one cycle and takes DONE->IDLE.

Top module: `fp_mask_cmp`

## Requirements
- R1: `funct3` 3'b001 selects the vector-vector form and 3'b101 the vector-scalar form. `funct6` selects the relation: 6'b011000 equal, 6'b011100 not-equal, 6'b011011 less-than, 6'b011001 less-or-equal, 6'b011101 greater-than, 6'b011111 greater-or-equal, 6'b011010 ordered. Any other `funct6` or `funct3` value is illegal.
- R2: Greater-than and greater-or-equal used with the vector-vector form are illegal, and so is `ew_sel`=2'b00 (8-bit). An illegal start sets `illegal_flag`, makes no write, and raises `done` in the cycle after the start edge.
- R3: Each written result is "src2 element REL operand", where the operand is the src1 element (vector-vector form) or `scalar_op` (vector-scalar form). `ew_sel` 2'b01/2'b10/2'b11 selects 16/32/64-bit elements held in the low bits of each 64-bit port. Higher bits, including those of the scalar, are ignored.
- R4: When either operand is a NaN, not-equal yields 1 and every other relation yields 0.
- R5: Equal, not-equal and ordered set `invalid_flag` only when an operand is a signaling NaN, that is a NaN whose most significant fraction bit is 0.
- R6: Less-than, less-or-equal, greater-than and greater-or-equal set `invalid_flag` when either operand is any NaN.
- R7: +0 and -0 compare equal. Ordering follows sign and magnitude, so among negatives the larger magnitude is the smaller value.
- R8: With `vm`=0, an index whose `v0_bit` is 0 produces no write and raises no flag.
- R9: Every index from `vl` up to `vlmax`-1 is written with 0 once the active indices are done. Indices at or above `vlmax` are never written.
- R10: Writes come one per cycle in ascending index order. `done` is a single-cycle pulse that coincides with the last write, and no write occurs outside a run.
- R11: A start accepted in IDLE clears both flags. The flags then hold until the next accepted start, and a `start` during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted in IDLE only) |
| funct6 | input | 6 | Relation code |
| funct3 | input | 3 | Operand form code |
| vm | input | 1 | 1 = unmasked, 0 = use v0 bits |
| ew_sel | input | 2 | Element width: 00 8, 01 16, 10 32, 11 64 bits |
| vl | input | CNT_W | Active element count |
| vlmax | input | CNT_W | Group element count (at most MAX_ELEMS) |
| elem_idx | output | IDX_W | Index of the element being read |
| src2_elem | input | 64 | Second source vector element at `elem_idx` |
| src1_elem | input | 64 | First source vector element at `elem_idx` |
| scalar_op | input | 64 | Scalar operand |
| v0_bit | input | 1 | v0 mask bit at `elem_idx` |
| mask_we | output | 1 | Mask bit write strobe |
| mask_idx | output | IDX_W | Mask bit index written |
| mask_bit | output | 1 | Mask bit value written |
| done | output | 1 | One-cycle completion pulse |
| invalid_flag | output | 1 | Accumulated invalid-operation flag |
| illegal_flag | output | 1 | Illegal-instruction flag |

## Verification
The checker assumes `vlmax` never exceeds MAX_ELEMS and `vl` never exceeds `vlmax`. It also assumes that the element ports return the value at `elem_idx` within the same cycle. The bench keeps to these limits: it draws `vlmax` from 1 to 64 and `vl` from 0 to `vlmax`, with a few directed runs at zero and full length. It serves the element ports combinationally from arrays indexed by `elem_idx`. It holds `start` low until the previous run has gone back to IDLE, except in runs that pulse `start` on purpose while busy.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int ELEN = 64;

    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } ew_e;

    typedef enum logic [2:0] {
        REL_EQ,
        REL_NE,
        REL_LT,
        REL_LE,
        REL_GT,
        REL_GE,
        REL_ORD
    } rel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } state_e;

    localparam logic [5:0] OPC_EQ  = 6'b011000;
    localparam logic [5:0] OPC_NE  = 6'b011100;
    localparam logic [5:0] OPC_LT  = 6'b011011;
    localparam logic [5:0] OPC_LE  = 6'b011001;
    localparam logic [5:0] OPC_GT  = 6'b011101;
    localparam logic [5:0] OPC_GE  = 6'b011111;
    localparam logic [5:0] OPC_ORD = 6'b011010;

    localparam logic [2:0] FORM_VV = 3'b001;
    localparam logic [2:0] FORM_VF = 3'b101;

    // exponent field width for a binary interchange format of width w
    function automatic int exp_bits(input int w);
        if (w == 16)      return 5;
        else if (w == 32) return 8;
        else              return 11;
    endfunction

endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
    import fcmp_pkg::*;
(
    input  logic [5:0] funct6,
    input  logic [2:0] funct3,
    input  logic [1:0] ew_sel,
    output rel_e       rel,
    output logic       is_vf,
    output logic       illegal
);

    logic bad_op;
    logic bad_form;
    logic scalar_only;

    always_comb begin
        rel    = REL_EQ;
        bad_op = 1'b0;
        unique case (funct6)
            OPC_EQ:  rel = REL_EQ;
            OPC_NE:  rel = REL_NE;
            OPC_LT:  rel = REL_LT;
            OPC_LE:  rel = REL_LE;
            OPC_GT:  rel = REL_GT;
            OPC_GE:  rel = REL_GE;
            OPC_ORD: rel = REL_ORD;
            default: bad_op = 1'b1;
        endcase
    end

    assign is_vf       = (funct3 == FORM_VF);
    assign bad_form    = (funct3 != FORM_VV) && !is_vf;
    assign scalar_only = (rel == REL_GT) || (rel == REL_GE);
    assign illegal     = bad_op || bad_form || (scalar_only && !is_vf)
                         || (ew_sel == EW8);

endmodule

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
    import fcmp_pkg::*;
#(
    parameter int W = 32,
    parameter int E = 8,
    localparam int F  = W - 1 - E,
    localparam int MW = ELEN - 1
) (
    input  logic [W-1:0]  x,
    output logic          is_nan,
    output logic          is_snan,
    output logic          sign,
    output logic [MW-1:0] mag
);

    logic exp_ones;
    logic frac_nz;

    assign exp_ones = &x[W-2:F];
    assign frac_nz  = |x[F-1:0];
    assign is_nan   = exp_ones && frac_nz;
    assign is_snan  = is_nan && !x[F-1];
    assign sign     = x[W-1];
    assign mag      = MW'(x[W-2:0]);

endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
#(
    localparam int MW = ELEN - 1
) (
    input  logic [ELEN-1:0] lhs,
    input  logic [ELEN-1:0] rhs,
    input  ew_e             ew,
    input  rel_e            rel,
    output logic            hit,
    output logic            invalid
);

    logic [2:0]    nan_l, snan_l, sgn_l;
    logic [2:0]    nan_r, snan_r, sgn_r;
    logic [MW-1:0] mag_l [3];
    logic [MW-1:0] mag_r [3];

    for (genvar g = 0; g < 3; g++) begin : g_fmt
        localparam int FW = 16 << g;
        localparam int FE = exp_bits(FW);
        fcmp_unpack #(.W(FW), .E(FE)) u_lhs (
            .x       (lhs[FW-1:0]),
            .is_nan  (nan_l[g]),
            .is_snan (snan_l[g]),
            .sign    (sgn_l[g]),
            .mag     (mag_l[g])
        );
        fcmp_unpack #(.W(FW), .E(FE)) u_rhs (
            .x       (rhs[FW-1:0]),
            .is_nan  (nan_r[g]),
            .is_snan (snan_r[g]),
            .sign    (sgn_r[g]),
            .mag     (mag_r[g])
        );
    end

    logic [1:0]    sel;
    logic          an, as, asg, bn, bs, bsg;
    logic [MW-1:0] am, bm;
    logic          unord, any_snan, both_zero, eq, lt, signaling;

    always_comb begin
        unique case (ew)
            EW16:    sel = 2'd0;
            EW32:    sel = 2'd1;
            default: sel = 2'd2;
        endcase
    end

    always_comb begin
        an  = nan_l[sel];
        as  = snan_l[sel];
        asg = sgn_l[sel];
        am  = mag_l[sel];
        bn  = nan_r[sel];
        bs  = snan_r[sel];
        bsg = sgn_r[sel];
        bm  = mag_r[sel];
    end

    assign unord     = an || bn;
    assign any_snan  = as || bs;
    assign both_zero = (am == '0) && (bm == '0);
    assign eq        = both_zero || ((asg == bsg) && (am == bm));

    always_comb begin
        if (both_zero)      lt = 1'b0;
        else if (asg != bsg) lt = asg;
        else if (!asg)       lt = (am < bm);
        else                 lt = (am > bm);
    end

    always_comb begin
        hit       = 1'b0;
        signaling = 1'b0;
        unique case (rel)
            REL_EQ:  hit = !unord && eq;
            REL_NE:  hit = unord || !eq;
            REL_LT:  begin hit = !unord && lt;          signaling = 1'b1; end
            REL_LE:  begin hit = !unord && (lt || eq);  signaling = 1'b1; end
            REL_GT:  begin hit = !unord && !(lt || eq); signaling = 1'b1; end
            REL_GE:  begin hit = !unord && !lt;         signaling = 1'b1; end
            default: hit = !unord;
        endcase
    end

    assign invalid = signaling ? unord : any_snan;

endmodule

// File: rtl/fp_mask_cmp.sv
module fp_mask_cmp
    import fcmp_pkg::*;
#(
    parameter int MAX_ELEMS = 64,
    localparam int IDX_W = $clog2(MAX_ELEMS),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [5:0]       funct6,
    input  logic [2:0]       funct3,
    input  logic             vm,
    input  logic [1:0]       ew_sel,
    input  logic [CNT_W-1:0] vl,
    input  logic [CNT_W-1:0] vlmax,
    output logic [IDX_W-1:0] elem_idx,
    input  logic [ELEN-1:0]  src2_elem,
    input  logic [ELEN-1:0]  src1_elem,
    input  logic [ELEN-1:0]  scalar_op,
    input  logic             v0_bit,
    output logic             mask_we,
    output logic [IDX_W-1:0] mask_idx,
    output logic             mask_bit,
    output logic             done,
    output logic             invalid_flag,
    output logic             illegal_flag
);

    state_e           state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    rel_e             rel_q;
    logic             vf_q;
    ew_e              ew_q;
    logic             vm_q;
    logic [CNT_W-1:0] vl_q;
    logic [CNT_W-1:0] vlmax_q;

    rel_e             dec_rel;
    logic             dec_vf;
    logic             dec_illegal;

    fcmp_decode u_decode (
        .funct6  (funct6),
        .funct3  (funct3),
        .ew_sel  (ew_sel),
        .rel     (dec_rel),
        .is_vf   (dec_vf),
        .illegal (dec_illegal)
    );

    logic [ELEN-1:0] rhs_op;
    logic            cmp_hit;
    logic            cmp_inv;

    assign rhs_op = vf_q ? scalar_op : src1_elem;

    fcmp_relate u_relate (
        .lhs     (src2_elem),
        .rhs     (rhs_op),
        .ew      (ew_q),
        .rel     (rel_q),
        .hit     (cmp_hit),
        .invalid (cmp_inv)
    );

    logic start_ok;
    logic in_body;
    logic active;
    logic at_last;

    assign start_ok = start && (state_q == ST_IDLE);
    assign in_body  = {1'b0, idx_q} < vl_q;
    assign active   = vm_q || v0_bit;
    assign at_last  = {1'b0, idx_q} == (vlmax_q - 1'b1);
    assign elem_idx = idx_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (dec_illegal || (vlmax == '0)) state_d = ST_DONE;
                    else                              state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (at_last) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and captured instruction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rel_q   <= REL_EQ;
            vf_q    <= 1'b0;
            ew_q    <= EW16;
            vm_q    <= 1'b1;
            vl_q    <= '0;
            vlmax_q <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                idx_q   <= '0;
                rel_q   <= dec_rel;
                vf_q    <= dec_vf;
                ew_q    <= ew_e'(ew_sel);
                vm_q    <= vm;
                vl_q    <= vl;
                vlmax_q <= vlmax;
            end else if (state_q == ST_RUN) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_we      <= 1'b0;
            mask_idx     <= '0;
            mask_bit     <= 1'b0;
            invalid_flag <= 1'b0;
            illegal_flag <= 1'b0;
        end else begin
            mask_we <= 1'b0;
            if (start_ok) begin
                invalid_flag <= 1'b0;
                illegal_flag <= dec_illegal;
            end
            if (state_q == ST_RUN) begin
                mask_idx <= idx_q;
                if (in_body) begin
                    if (active) begin
                        mask_we  <= 1'b1;
                        mask_bit <= cmp_hit;
                        if (cmp_inv) invalid_flag <= 1'b1;
                    end
                end else begin
                    mask_we  <= 1'b1;
                    mask_bit <= 1'b0;
                end
            end
        end
    end

    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/fp_mask_cmp_chk.sv
module fp_mask_cmp_chk
    import fcmp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             mask_we,
    input logic [IDX_W-1:0] mask_idx,
    input logic             mask_bit,
    input logic             invalid_flag,
    input logic             illegal_flag,
    input state_e           state_q,
    input logic [CNT_W-1:0] vl_q
);

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_flag |-> !mask_we); // R2

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && ({1'b0, mask_idx} >= vl_q)) |-> !mask_bit); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && $past(mask_we)) |-> (mask_idx == $past(mask_idx) + 1'b1)); // R10

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mask_we); // R10

    AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag && !start) |=> invalid_flag); // R11

    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_flag && !start) |=> illegal_flag); // R11

endmodule

bind fp_mask_cmp fp_mask_cmp_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .done         (done),
    .mask_we      (mask_we),
    .mask_idx     (mask_idx),
    .mask_bit     (mask_bit),
    .invalid_flag (invalid_flag),
    .illegal_flag (illegal_flag),
    .state_q      (state_q),
    .vl_q         (vl_q)
);

// File: tb/fp_mask_cmp_tb.sv
module fp_mask_cmp_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    localparam logic [5:0] F_EQ  = 6'b011000;
    localparam logic [5:0] F_NE  = 6'b011100;
    localparam logic [5:0] F_LT  = 6'b011011;
    localparam logic [5:0] F_LE  = 6'b011001;
    localparam logic [5:0] F_GT  = 6'b011101;
    localparam logic [5:0] F_GE  = 6'b011111;
    localparam logic [5:0] F_ORD = 6'b011010;
    localparam logic [2:0] VV = 3'b001;
    localparam logic [2:0] VF = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [5:0]  funct6;
    logic [2:0]  funct3;
    logic        vm;
    logic [1:0]  ew_sel;
    logic [6:0]  vl, vlmax;
    logic [5:0]  elem_idx;
    logic [63:0] src2_elem, src1_elem, scalar_op;
    logic        v0_bit;
    logic        mask_we;
    logic [5:0]  mask_idx;
    logic        mask_bit;
    logic        done;
    logic        invalid_flag, illegal_flag;

    logic [63:0] vs2_m [N];
    logic [63:0] vs1_m [N];
    logic        v0_m  [N];
    logic        img   [N];
    logic        want  [N];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign src2_elem = vs2_m[elem_idx];
    assign src1_elem = vs1_m[elem_idx];
    assign v0_bit    = v0_m[elem_idx];

    fp_mask_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .funct6(funct6), .funct3(funct3),
        .vm(vm), .ew_sel(ew_sel), .vl(vl), .vlmax(vlmax), .elem_idx(elem_idx),
        .src2_elem(src2_elem), .src1_elem(src1_elem), .scalar_op(scalar_op),
        .v0_bit(v0_bit), .mask_we(mask_we), .mask_idx(mask_idx), .mask_bit(mask_bit),
        .done(done), .invalid_flag(invalid_flag), .illegal_flag(illegal_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic int ebw(input int w);
        return (w == 16) ? 5 : (w == 32) ? 8 : 11;
    endfunction

    function automatic logic [63:0] wmask(input int w);
        return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic bit nan_of(input logic [63:0] x, input int w);
        int e = ebw(w);
        int f = w - 1 - e;
        logic [63:0] ex = (x >> f) & ((64'd1 << e) - 64'd1);
        logic [63:0] fr = x & ((64'd1 << f) - 64'd1);
        return (ex == ((64'd1 << e) - 64'd1)) && (fr != 0);
    endfunction

    function automatic bit snan_of(input logic [63:0] x, input int w);
        int f = w - 1 - ebw(w);
        return nan_of(x, w) && !x[f-1];
    endfunction

    // signed ordering key: sign/magnitude folded to a two's-complement value
    function automatic longint key_of(input logic [63:0] x, input int w);
        logic [63:0] m = x & ((64'd1 << (w - 1)) - 64'd1);
        return x[w-1] ? -longint'(m) : longint'(m);
    endfunction

    // returns {invalid, result}
    function automatic logic [1:0] ref_cmp(input logic [63:0] a0, input logic [63:0] b0,
                                           input int w, input logic [5:0] f6);
        logic [63:0] a = a0 & wmask(w);
        logic [63:0] b = b0 & wmask(w);
        bit un = nan_of(a, w) || nan_of(b, w);
        bit sn = snan_of(a, w) || snan_of(b, w);
        longint ka = key_of(a, w);
        longint kb = key_of(b, w);
        case (f6)
            F_EQ:    return {sn, !un && (ka == kb)};
            F_NE:    return {sn, un || (ka != kb)};
            F_LT:    return {un, !un && (ka <  kb)};
            F_LE:    return {un, !un && (ka <= kb)};
            F_GT:    return {un, !un && (ka >  kb)};
            F_GE:    return {un, !un && (ka >= kb)};
            default: return {sn, !un};
        endcase
    endfunction

    function automatic bit legal_of(input logic [5:0] f6, input logic [2:0] f3, input int w);
        bit known = (f6 == F_EQ) || (f6 == F_NE) || (f6 == F_LT) || (f6 == F_LE) ||
                    (f6 == F_GT) || (f6 == F_GE) || (f6 == F_ORD);
        if (!known) return 0;
        if (f3 != VV && f3 != VF) return 0;
        if ((f6 == F_GT || f6 == F_GE) && f3 == VV) return 0;
        return w != 8;
    endfunction

    // ---------------- stimulus helpers ----------------
    function automatic logic [63:0] special(input int w, input int kind);
        int e = ebw(w);
        int f = w - 1 - e;
        logic [63:0] eo = ((64'd1 << e) - 64'd1) << f;
        case (kind)
            0: return 64'd0;
            1: return 64'd1 << (w - 1);
            2: return eo | (64'd1 << (f - 1));
            3: return eo | 64'd1;
            4: return eo;
            5: return eo | (64'd1 << (w - 1));
            6: return (64'(e) << f) | 64'($urandom % 8) | (64'($urandom % 2) << (w - 1));
            default: return {$urandom, $urandom} & wmask(w);
        endcase
    endfunction

    function automatic logic [63:0] gen_val(input int w);
        logic [63:0] junk = {$urandom, $urandom} & ~wmask(w);
        return special(w, int'($urandom % 10)) | junk;
    endfunction

    task automatic fill_random(input int w);
        for (int i = 0; i < N; i++) begin
            int r = int'($urandom % 4);
            vs2_m[i] = gen_val(w);
            if (r == 0)      vs1_m[i] = vs2_m[i];
            else if (r == 1) vs1_m[i] = vs2_m[i] ^ (64'd1 << (w - 1));
            else             vs1_m[i] = gen_val(w);
            v0_m[i] = 1'($urandom % 2);
        end
        scalar_op = gen_val(w);
        for (int i = 0; i < N; i += 5) vs2_m[i] = scalar_op;
    endtask

    function automatic logic [1:0] ew_code(input int w);
        return (w == 16) ? 2'b01 : (w == 32) ? 2'b10 : (w == 64) ? 2'b11 : 2'b00;
    endfunction

    // ---------------- one instruction ----------------
    task automatic run_op(input logic [5:0] f6, input logic [2:0] f3, input bit vmi,
                          input int w, input int vlv, input int vlmaxv,
                          input int poke, input string req);
        bit legal = legal_of(f6, f3, w);
        bit einv = 0;
        int ewr = 0;
        int nwr = 0;
        int ndone = 0;
        int lastw = -1;
        bit order_ok = 1;
        int cyc = 0;
        int bad = -1;
        for (int i = 0; i < N; i++) begin
            img[i]  = 1'($urandom % 2);
            want[i] = img[i];
        end
        if (legal) begin
            for (int i = 0; i < vlmaxv; i++) begin
                if (i < vlv) begin
                    if (vmi || v0_m[i]) begin
                        logic [1:0] r = ref_cmp(vs2_m[i], (f3 == VF) ? scalar_op : vs1_m[i], w, f6);
                        want[i] = r[0];
                        einv |= r[1];
                        ewr++;
                    end
                end else begin
                    want[i] = 1'b0;
                    ewr++;
                end
            end
        end
        @(negedge clk);
        funct6 = f6; funct3 = f3; vm = vmi; ew_sel = ew_code(w);
        vl = 7'(vlv); vlmax = 7'(vlmaxv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            if (cyc == poke) begin
                start = 1'b1; funct6 = 6'b000000; ew_sel = 2'b00;
            end else begin
                start = 1'b0;
            end
            if (mask_we) begin
                if (int'(mask_idx) <= lastw) order_ok = 0;
                lastw = int'(mask_idx);
                img[mask_idx] = mask_bit;
                nwr++;
            end
            if (done) begin
                ndone++;
                break;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 300) break;
        end
        start = 1'b0;
        @(negedge clk);
        if (done) ndone++;
        for (int i = N - 1; i >= 0; i--) if (img[i] !== want[i]) bad = i;
        check(bad < 0, req, "first mismatching mask index", bad, -1);
        check(invalid_flag == einv, req, "invalid_flag", invalid_flag, einv);
        check(illegal_flag == !legal, req, "illegal_flag", illegal_flag, !legal);
        check(nwr == ewr, "R10", "write count", nwr, ewr);
        check(ndone == 1, "R10", "done pulses", ndone, 1);
        check(order_ok, "R10", "ascending writes", order_ok, 1);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [5:0] ops [7] = '{F_EQ, F_NE, F_LT, F_LE, F_GT, F_GE, F_ORD};
        void'($urandom(32'd1234));
        rst_n = 1'b0; start = 1'b0; funct6 = '0; funct3 = '0; vm = 1'b1;
        ew_sel = 2'b01; vl = '0; vlmax = '0; scalar_op = '0;
        for (int i = 0; i < N; i++) begin vs2_m[i] = '0; vs1_m[i] = '0; v0_m[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check(!done && !mask_we && !invalid_flag && !illegal_flag, "R11", "reset outputs",
              {done, mask_we, invalid_flag, illegal_flag}, 0);
        rst_n = 1'b1;

        // R1/R3: every relation, both forms, each width
        foreach (ops[k]) begin
            fill_random(32);
            run_op(ops[k], VF, 1'b1, 32, 16, 16, -1, "R3");
            fill_random(16);
            if (ops[k] != F_GT && ops[k] != F_GE) run_op(ops[k], VV, 1'b1, 16, 20, 24, -1, "R1");
            fill_random(64);
            run_op(ops[k], VF, 1'b1, 64, 12, 12, -1, "R3");
        end

        // R7: signed zeros and negative ordering, single precision
        for (int i = 0; i < N; i++) begin
            vs2_m[i] = (i % 2) ? 64'hC000_0000 : 64'h0000_0000;
            vs1_m[i] = (i % 2) ? 64'hBF80_0000 : 64'h8000_0000;
        end
        run_op(F_EQ, VV, 1'b1, 32, 8, 8, -1, "R7");
        run_op(F_LT, VV, 1'b1, 32, 8, 8, -1, "R7");
        run_op(F_LE, VV, 1'b1, 32, 8, 8, -1, "R7");

        // R4/R5/R6: quiet NaN against numbers, then signaling NaN
        for (int i = 0; i < N; i++) begin vs2_m[i] = special(32, 2); vs1_m[i] = 64'h3F80_0000; end
        run_op(F_NE,  VV, 1'b1, 32, 4, 4, -1, "R4");
        run_op(F_ORD, VV, 1'b1, 32, 4, 4, -1, "R4");
        run_op(F_EQ,  VV, 1'b1, 32, 4, 4, -1, "R5");
        run_op(F_LT,  VV, 1'b1, 32, 4, 4, -1, "R6");
        for (int i = 0; i < N; i++) vs1_m[i] = special(32, 3);
        run_op(F_ORD, VV, 1'b1, 32, 4, 4, -1, "R5");

        // R2: illegal encodings
        fill_random(32);
        run_op(F_GT, VV, 1'b1, 32, 8, 8, -1, "R2");
        run_op(F_GE, VV, 1'b1, 32, 8, 8, -1, "R2");
        run_op(F_EQ, VF, 1'b1, 8, 8, 8, -1, "R2");
        run_op(F_EQ, 3'b000, 1'b1, 32, 8, 8, -1, "R1");
        run_op(6'b000111, VV, 1'b1, 32, 8, 8, -1, "R1");

        // R8: masked-off lanes carry signaling NaNs under a signaling relation
        for (int i = 0; i < N; i++) begin
            v0_m[i]  = (i % 3 == 0);
            vs2_m[i] = v0_m[i] ? 64'h3C00 : special(16, 3);
            vs1_m[i] = 64'h4000;
        end
        run_op(F_LT, VV, 1'b0, 16, 30, 30, -1, "R8");

        // R9: tail clearing, zero active length, full group
        fill_random(64);
        run_op(F_LE, VV, 1'b1, 64, 5, 20, -1, "R9");
        run_op(F_NE, VF, 1'b0, 64, 0, 10, -1, "R9");
        run_op(F_GE, VF, 1'b0, 32, 64, 64, -1, "R9");

        // R11: start pulses while busy are ignored; flags reset by a new start
        fill_random(32);
        run_op(F_LT, VV, 1'b1, 32, 20, 30, 3, "R11");
        for (int i = 0; i < N; i++) begin vs2_m[i] = 64'h3F80_0000; vs1_m[i] = 64'h4000_0000; end
        run_op(F_LT, VV, 1'b1, 32, 10, 10, -1, "R11");

        // constrained random
        for (int n = 0; n < 150; n++) begin
            int wsel = int'($urandom % 3);
            int w = 16 << wsel;
            logic [5:0] f6 = ops[$urandom % 7];
            logic [2:0] f3 = (f6 == F_GT || f6 == F_GE || ($urandom % 2)) ? VF : VV;
            int vmx = 1 + int'($urandom % 64);
            int vlr = int'($urandom % (vmx + 1));
            int pk = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
            fill_random(w);
            run_op(f6, f3, 1'($urandom % 2), w, vlr, vmx, pk, "R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule